// File: doc/BRIEF.md
# Scratchpad Replica Coalescing Line Buffer

This block sits between the scratchpad write path and the data cache and keeps the newest copy of exactly one cache line's worth of scratchpad words. The cache holds the replica that lets a parity-detected scratchpad error be repaired. A scratchpad write whose line matches the buffered line is merged into the buffer byte by byte, and the cache is not touched. A write to another line first sends the buffered line to the cache and then takes the buffer over. Only written data is ever replicated, because clean scratchpad lines already have a copy further down the hierarchy.

A write-back runs in two steps. First a probe asks the cache whether a replica line for the tag already exists. Then the write request carries the line, a per-word mask and an allocate flag. The flag tells the cache either to overwrite the existing replica or to pick a new line for it. New scratchpad writes stall until the cache acknowledges. A flush command empties the buffer through the same path. A combinational lookup port lets error recovery read the newest copy of a word, and it takes precedence over the copy in the cache.

Top module: `spm_replica_buf`

## Requirements
- R1: After reset the buffer is empty: `wr_ready` is 1, `probe_valid`, `wb_valid` and `flush_done` are 0, and every lookup misses.
- R2: A write to an empty buffer is accepted at once and issues no probe or write-back. From the next cycle the buffer holds that line.
- R3: A write whose line tag (address bits 31:5) equals the buffered tag updates only the bytes of word address[4:2] selected by `wr_be` (bit b selects data bits 8b+7:8b). It causes no cache traffic.
- R4: A write to a different line while the buffer is valid is accepted. In the next cycle `probe_valid` rises with `probe_tag` equal to the old tag, and `wr_ready` stays 0 until the cycle after `wb_ack`.
- R5: After the probe response, `wb_valid` presents the old tag, its 256-bit data (word i at bits 32i+31:32i) and its mask. `wb_alloc` is the inverse of the sampled `probe_hit`: 0 rewrites an existing replica and 1 allocates a new one.
- R6: While `wb_valid` is 1 and `wb_ack` is 0, the write-back request and its tag, data, mask and allocate flag do not change.
- R7: In the cycle after `wb_ack` that ends a miss, the buffer holds only the new write's line. Its other words are invalid, and bytes not enabled in the written word are 0.
- R8: Mask bit i is 1 exactly when some byte of word i has been written since the line was taken. A write with `wr_be` = 0 changes no data and no mask bit.
- R9: A flush with a valid buffer runs a probe and a write-back. `flush_done` pulses for one cycle after `wb_ack`, and the buffer is then empty.
- R10: A flush with an empty buffer raises `flush_done` in the next cycle, with no cache traffic.
- R11: `lk_hit` is 1 exactly when the buffer is valid, the tag of `lk_addr` matches, and the mask bit of word `lk_addr[4:2]` is set. `lk_data` then returns that word.
- R12: A one-cycle `flush_req` that arrives while a write-back is in progress, or during an accepted write, is remembered. It is executed once the block returns to idle with no write offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | Scratchpad write offered |
| wr_ready | output | 1 | Write accepted this cycle when high |
| wr_addr | input | 32 | Byte address of the write |
| wr_data | input | 32 | Write data word |
| wr_be | input | 4 | Byte enables |
| flush_req | input | 1 | Flush request pulse |
| flush_done | output | 1 | One-cycle flush completion |
| probe_valid | output | 1 | Asks whether a replica line for probe_tag exists |
| probe_tag | output | 27 | Tag being probed |
| probe_done | input | 1 | Probe answered this cycle |
| probe_hit | input | 1 | Replica line already present |
| wb_valid | output | 1 | Line write-back request |
| wb_tag | output | 27 | Line address of the write-back |
| wb_alloc | output | 1 | Cache must allocate a new replica line |
| wb_data | output | 256 | Line data |
| wb_mask | output | 8 | Per-word valid mask |
| wb_ack | input | 1 | Cache accepted the write-back |
| lk_addr | input | 32 | Recovery lookup byte address |
| lk_hit | output | 1 | Lookup served by the buffer |
| lk_data | output | 32 | Buffered word for lk_addr |

## Verification
Directed patterns separate the three kinds of write: a first write into an empty buffer, runs of same-line writes with partial and empty byte enables, and line-changing writes. Each line-changing write is answered once with a probe hit and once with a probe miss, so a swapped allocate flag shows up. Flushes of a full and of an empty buffer, and a flush pulse that lands mid write-back, tell the deferred path apart from the immediate one. A long randomized stream over three lines, with varying response delays and interleaved lookups, is compared cycle by cycle with a behavioural model. This catches wrong merging, lost mask bits and write-backs that move or are mistimed.

// File: rtl/spm_rb_pkg.sv
// Package: shared state encoding for the replica line buffer.
// Assumes: nothing beyond standard SystemVerilog.
package spm_rb_pkg;
    typedef enum logic [1:0] {
        RB_IDLE  = 2'd0,
        RB_PROBE = 2'd1,
        RB_WRITE = 2'd2
    } rb_state_e;
endpackage

// File: rtl/spm_rb_line.sv
// Module: one-line storage with byte-merge, per-word mask and lookup.
// Assumes: at most one of op_merge / op_install / op_clear per cycle.
module spm_rb_line #(
    parameter int ADDR_W     = 32,
    parameter int WORD_W     = 32,
    parameter int LINE_WORDS = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         op_merge,
    input  logic                         op_install,
    input  logic                         op_clear,
    input  logic [ADDR_W-$clog2(LINE_WORDS*(WORD_W/8))-1:0] in_tag,
    input  logic [$clog2(LINE_WORDS)-1:0] in_idx,
    input  logic [WORD_W-1:0]            in_data,
    input  logic [WORD_W/8-1:0]          in_be,
    input  logic [ADDR_W-$clog2(LINE_WORDS*(WORD_W/8))-1:0] lk_tag,
    input  logic [$clog2(LINE_WORDS)-1:0] lk_idx,
    output logic                         valid,
    output logic [ADDR_W-$clog2(LINE_WORDS*(WORD_W/8))-1:0] tag,
    output logic [LINE_WORDS*WORD_W-1:0] line_data,
    output logic [LINE_WORDS-1:0]        mask,
    output logic                         lk_hit,
    output logic [WORD_W-1:0]            lk_word
);
    localparam int BYTES = WORD_W / 8;
    localparam int IDX_W = $clog2(LINE_WORDS);

    logic [WORD_W-1:0] words [LINE_WORDS];
    logic              any_be;

    assign any_be = |in_be;

    function automatic logic [WORD_W-1:0] merge_word(
        input logic [WORD_W-1:0] old_w,
        input logic [WORD_W-1:0] new_w,
        input logic [BYTES-1:0]  be);
        logic [WORD_W-1:0] r;
        r = old_w;
        for (int b = 0; b < BYTES; b++)
            if (be[b]) r[b*8 +: 8] = new_w[b*8 +: 8];
        return r;
    endfunction

    // Tag and valid bit of the held line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            tag   <= '0;
        end else if (op_install) begin
            valid <= 1'b1;
            tag   <= in_tag;
        end else if (op_clear) begin
            valid <= 1'b0;
        end
    end

    for (genvar g = 0; g < LINE_WORDS; g++) begin : g_word
        logic sel;
        assign sel = (in_idx == IDX_W'(g));

        // Word storage: cleared on install except for the written word.
        always_ff @(posedge clk) begin
            if (!rst_n)
                words[g] <= '0;
            else if (op_install)
                words[g] <= sel ? merge_word('0, in_data, in_be) : '0;
            else if (op_merge && sel)
                words[g] <= merge_word(words[g], in_data, in_be);
        end

        // Word valid bit: set by any enabled byte, dropped on install/clear.
        always_ff @(posedge clk) begin
            if (!rst_n)
                mask[g] <= 1'b0;
            else if (op_install)
                mask[g] <= sel && any_be;
            else if (op_clear)
                mask[g] <= 1'b0;
            else if (op_merge && sel && any_be)
                mask[g] <= 1'b1;
        end

        assign line_data[g*WORD_W +: WORD_W] = words[g];
    end

    assign lk_hit  = valid && (lk_tag == tag) && mask[lk_idx];
    assign lk_word = words[lk_idx];

    assert_mask_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
        op_merge |=> ((mask & $past(mask)) == $past(mask)));
    assert_install_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        op_install |=> valid);
    assert_single_op_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({op_merge, op_install, op_clear}));
endmodule

// File: rtl/spm_rb_ctrl.sv
// Module: sequencing of merge, miss write-back, flush and stall.
// Assumes: probe_done and wb_ack are only meaningful in their own phase.
module spm_rb_ctrl
    import spm_rb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_valid,
    input  logic buf_valid,
    input  logic tag_match,
    input  logic flush_req,
    input  logic probe_done,
    input  logic probe_hit,
    input  logic wb_ack,
    output logic wr_ready,
    output logic probe_valid,
    output logic wb_valid,
    output logic wb_alloc,
    output logic flush_done,
    output logic op_merge,
    output logic op_install_wr,
    output logic op_install_pend,
    output logic op_clear,
    output logic pend_load
);
    rb_state_e state;
    logic idle, wr_take, flush_want, start_flush, empty_flush, ack_done;
    logic flush_pend, pend_wr, hit_r;

    assign idle        = (state == RB_IDLE);
    assign wr_ready    = idle;
    assign probe_valid = (state == RB_PROBE);
    assign wb_valid    = (state == RB_WRITE);
    assign wb_alloc    = !hit_r;

    assign wr_take       = idle && wr_valid;
    assign op_merge      = wr_take && buf_valid && tag_match;
    assign op_install_wr = wr_take && !buf_valid;
    assign pend_load     = wr_take && buf_valid && !tag_match;
    assign flush_want    = flush_pend || flush_req;
    assign start_flush   = idle && !wr_valid && flush_want && buf_valid;
    assign empty_flush   = idle && !wr_valid && flush_want && !buf_valid;
    assign ack_done      = wb_valid && wb_ack;
    assign op_install_pend = ack_done && pend_wr;
    assign op_clear        = ack_done && !pend_wr;

    // Phase sequencing: idle -> probe -> write -> idle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= RB_IDLE;
        else case (state)
            RB_IDLE:  if (pend_load || start_flush) state <= RB_PROBE;
            RB_PROBE: if (probe_done) state <= RB_WRITE;
            RB_WRITE: if (wb_ack) state <= RB_IDLE;
            default:  state <= RB_IDLE;
        endcase
    end

    // Remembers a flush request until the block is free to run it.
    always_ff @(posedge clk) begin
        if (!rst_n) flush_pend <= 1'b0;
        else        flush_pend <= flush_want && !(idle && !wr_valid);
    end

    // Cause of the write-back in flight, and the probe answer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_wr <= 1'b0;
            hit_r   <= 1'b0;
        end else begin
            if (pend_load)        pend_wr <= 1'b1;
            else if (start_flush) pend_wr <= 1'b0;
            if (probe_valid && probe_done) hit_r <= probe_hit;
        end
    end

    // One-cycle completion pulse for a flush.
    always_ff @(posedge clk) begin
        if (!rst_n) flush_done <= 1'b0;
        else        flush_done <= empty_flush || op_clear;
    end

    assert_hold_request_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && !wb_ack) |=> (wb_valid && $stable(wb_alloc)));
    assert_stall_on_miss_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pend_load |=> (probe_valid && !wr_ready));
    assert_phases_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(probe_valid && wb_valid));
endmodule

// File: rtl/spm_replica_buf.sv
// Module: top of the scratchpad replica coalescing line buffer.
// Assumes: the cache answers every probe and acknowledges every write-back.
module spm_replica_buf #(
    parameter int ADDR_W     = 32,
    parameter int WORD_W     = 32,
    parameter int LINE_WORDS = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_valid,
    output logic                         wr_ready,
    input  logic [ADDR_W-1:0]            wr_addr,
    input  logic [WORD_W-1:0]            wr_data,
    input  logic [WORD_W/8-1:0]          wr_be,
    input  logic                         flush_req,
    output logic                         flush_done,
    output logic                         probe_valid,
    output logic [ADDR_W-$clog2(LINE_WORDS*(WORD_W/8))-1:0] probe_tag,
    input  logic                         probe_done,
    input  logic                         probe_hit,
    output logic                         wb_valid,
    output logic [ADDR_W-$clog2(LINE_WORDS*(WORD_W/8))-1:0] wb_tag,
    output logic                         wb_alloc,
    output logic [LINE_WORDS*WORD_W-1:0] wb_data,
    output logic [LINE_WORDS-1:0]        wb_mask,
    input  logic                         wb_ack,
    input  logic [ADDR_W-1:0]            lk_addr,
    output logic                         lk_hit,
    output logic [WORD_W-1:0]            lk_data
);
    localparam int BYTES = WORD_W / 8;
    localparam int BOFF  = $clog2(BYTES);
    localparam int OFF_W = $clog2(LINE_WORDS * BYTES);
    localparam int IDX_W = $clog2(LINE_WORDS);
    localparam int TAG_W = ADDR_W - OFF_W;

    logic [TAG_W-1:0] wr_tag, buf_tag, pend_tag, in_tag;
    logic [IDX_W-1:0] wr_idx, pend_idx, in_idx;
    logic [WORD_W-1:0] pend_data, in_data;
    logic [BYTES-1:0]  pend_be, in_be;
    logic buf_valid, op_merge, op_install_wr, op_install_pend, op_clear, pend_load;

    assign wr_tag = wr_addr[ADDR_W-1:OFF_W];
    assign wr_idx = wr_addr[OFF_W-1:BOFF];

    // Holds the write that missed until the old line has left.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_tag  <= '0;
            pend_idx  <= '0;
            pend_data <= '0;
            pend_be   <= '0;
        end else if (pend_load) begin
            pend_tag  <= wr_tag;
            pend_idx  <= wr_idx;
            pend_data <= wr_data;
            pend_be   <= wr_be;
        end
    end

    assign in_tag  = op_install_pend ? pend_tag  : wr_tag;
    assign in_idx  = op_install_pend ? pend_idx  : wr_idx;
    assign in_data = op_install_pend ? pend_data : wr_data;
    assign in_be   = op_install_pend ? pend_be   : wr_be;

    spm_rb_ctrl u_ctrl (
        .clk, .rst_n, .wr_valid,
        .buf_valid, .tag_match(wr_tag == buf_tag),
        .flush_req, .probe_done, .probe_hit, .wb_ack,
        .wr_ready, .probe_valid, .wb_valid, .wb_alloc, .flush_done,
        .op_merge, .op_install_wr, .op_install_pend, .op_clear, .pend_load
    );

    spm_rb_line #(
        .ADDR_W(ADDR_W), .WORD_W(WORD_W), .LINE_WORDS(LINE_WORDS)
    ) u_line (
        .clk, .rst_n,
        .op_merge, .op_install(op_install_wr || op_install_pend), .op_clear,
        .in_tag, .in_idx, .in_data, .in_be,
        .lk_tag(lk_addr[ADDR_W-1:OFF_W]), .lk_idx(lk_addr[OFF_W-1:BOFF]),
        .valid(buf_valid), .tag(buf_tag), .line_data(wb_data), .mask(wb_mask),
        .lk_hit, .lk_word(lk_data)
    );

    assign probe_tag = buf_tag;
    assign wb_tag    = buf_tag;

    assert_line_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && !wb_ack) |=> ($stable(wb_data) && $stable(wb_tag) && $stable(wb_mask)));
    assert_flush_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush_done |-> !buf_valid);
    assert_probe_has_line_R4: assert property (@(posedge clk) disable iff (!rst_n)
        probe_valid |-> buf_valid);
    assert_ready_after_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
        op_install_pend |=> (wr_ready && buf_valid && !wb_valid));
endmodule

// File: tb/spm_replica_buf_test.sv
module spm_replica_buf_test;
    localparam int CLK_PERIOD = 10;

    logic clk = 0, rst_n = 0;
    logic wr_valid = 0, wr_ready;
    logic [31:0] wr_addr = 0, wr_data = 0;
    logic [3:0]  wr_be = 0;
    logic flush_req = 0, flush_done;
    logic probe_valid, probe_done = 0, probe_hit = 0;
    logic [26:0] probe_tag, wb_tag;
    logic wb_valid, wb_alloc, wb_ack = 0;
    logic [255:0] wb_data;
    logic [7:0] wb_mask;
    logic [31:0] lk_addr = 0, lk_data;
    logic lk_hit;

    int n_cmp = 0, n_bad = 0, cyc = 0;
    int p_delay = 0, w_delay = 0, pcnt = 0, wcnt = 0;
    bit p_hit_k = 0, model_on = 0;

    // behavioural model state
    int m_state = 0;
    bit m_valid = 0, m_hit = 0, m_pwr = 0, m_fpend = 0, m_fdone = 0;
    logic [26:0] m_tag = 0, q_tag = 0;
    logic [31:0] m_w [8];
    logic [7:0]  m_mask = 0;
    logic [31:0] q_addr = 0, q_data = 0;
    logic [3:0]  q_be = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spm_replica_buf uut (.*);

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mrg(input logic [31:0] o, input logic [31:0] d,
                                        input logic [3:0] be);
        logic [31:0] r = o;
        for (int b = 0; b < 4; b++) if (be[b]) r[b*8 +: 8] = d[b*8 +: 8];
        return r;
    endfunction

    task automatic m_install(input logic [31:0] a, input logic [31:0] d, input logic [3:0] be);
        for (int i = 0; i < 8; i++) m_w[i] = 0;
        m_w[a[4:2]] = mrg(0, d, be);
        m_mask = (be != 0) ? (8'd1 << a[4:2]) : 8'd0;
        m_valid = 1;
        m_tag = a[31:5];
    endtask

    // Reference model: advances on every rising edge.
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_state = 0; m_valid = 0; m_mask = 0; m_fpend = 0; m_fdone = 0;
            m_hit = 0; m_pwr = 0; m_tag = 0;
            for (int i = 0; i < 8; i++) m_w[i] = 0;
        end else begin
            bit want, idle_free;
            want = m_fpend || flush_req;
            idle_free = (m_state == 0) && !wr_valid;
            m_fdone = 0;
            case (m_state)
                0: if (wr_valid) begin
                       if (m_valid && wr_addr[31:5] == m_tag) begin
                           m_w[wr_addr[4:2]] = mrg(m_w[wr_addr[4:2]], wr_data, wr_be);
                           if (wr_be != 0) m_mask[wr_addr[4:2]] = 1;
                       end else if (!m_valid) m_install(wr_addr, wr_data, wr_be);
                       else begin
                           q_addr = wr_addr; q_data = wr_data; q_be = wr_be;
                           m_pwr = 1; m_state = 1;
                       end
                   end else if (want) begin
                       if (m_valid) begin m_pwr = 0; m_state = 1; end
                       else m_fdone = 1;
                   end
                1: if (probe_done) begin m_hit = probe_hit; m_state = 2; end
                default: if (wb_ack) begin
                       if (m_pwr) m_install(q_addr, q_data, q_be);
                       else begin m_valid = 0; m_mask = 0; m_fdone = 1; end
                       m_state = 0;
                   end
            endcase
            m_fpend = want && !idle_free;
        end
    end

    // Cycle-by-cycle comparison, just after the falling edge.
    always @(negedge clk) begin
        #1;
        if (model_on && rst_n) begin
            logic [255:0] ld;
            bit eh;
            for (int i = 0; i < 8; i++) ld[i*32 +: 32] = m_w[i];
            eh = m_valid && lk_addr[31:5] == m_tag && m_mask[lk_addr[4:2]];
            chk(wr_ready == (m_state == 0), "R4", "wr_ready", wr_ready, m_state == 0);
            chk(probe_valid == (m_state == 1), "R4", "probe_valid", probe_valid, m_state == 1);
            if (probe_valid) chk(probe_tag == m_tag, "R4", "probe_tag", probe_tag, m_tag);
            chk(wb_valid == (m_state == 2), "R5", "wb_valid", wb_valid, m_state == 2);
            if (wb_valid) begin
                chk(wb_alloc == !m_hit, "R5", "wb_alloc", wb_alloc, !m_hit);
                chk(wb_tag == m_tag, "R6", "wb_tag", wb_tag, m_tag);
                chk(wb_data == ld, "R6", "wb_data", wb_data, ld);
                chk(wb_mask == m_mask, "R8", "wb_mask", wb_mask, m_mask);
            end
            chk(flush_done == m_fdone, "R9", "flush_done", flush_done, m_fdone);
            chk(lk_hit == eh, "R11", "lk_hit", lk_hit, eh);
            if (eh) chk(lk_data == m_w[lk_addr[4:2]], "R11", "lk_data", lk_data, m_w[lk_addr[4:2]]);
        end
    end

    // Cache responder: answers probes and write-backs after set delays.
    always @(negedge clk) begin
        if (probe_valid && !probe_done) begin
            if (pcnt >= p_delay) begin probe_done = 1; probe_hit = p_hit_k; pcnt = 0; end
            else pcnt++;
        end else probe_done = 0;
        if (wb_valid && !wb_ack) begin
            if (wcnt >= w_delay) begin wb_ack = 1; wcnt = 0; end
            else wcnt++;
        end else wb_ack = 0;
    end

    task automatic do_write(input logic [31:0] a, input logic [31:0] d, input logic [3:0] be);
        wr_valid = 1; wr_addr = a; wr_data = d; wr_be = be;
        #1;
        while (!wr_ready) begin @(negedge clk); #0; end
        @(negedge clk);
        wr_valid = 0;
    endtask

    task automatic pulse_flush();
        flush_req = 1;
        @(negedge clk);
        flush_req = 0;
    endtask

    task automatic wait_idle();
        #1;
        while (!wr_ready) begin @(negedge clk); #1; end
    endtask

    task automatic look(input logic [31:0] a);
        lk_addr = a; #1;
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) if (cyc == 150000) begin
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        model_on = 1;
        @(negedge clk); #1;
        // R1: empty after reset
        chk(wr_ready && !probe_valid && !wb_valid && !flush_done, "R1", "idle outputs",
            {wr_ready, probe_valid, wb_valid, flush_done}, 4'b1000);
        look(32'h1000);
        chk(!lk_hit, "R1", "lookup after reset", lk_hit, 0);

        // R2: first write into empty buffer
        do_write(32'h1000, 32'hA5A5_0001, 4'hF);
        #1;
        chk(!probe_valid && !wb_valid, "R2", "no cache traffic", {probe_valid, wb_valid}, 0);
        look(32'h1000);
        chk(lk_hit && lk_data == 32'hA5A5_0001, "R2", "lookup word0", lk_data, 32'hA5A5_0001);

        // R3/R8: byte merging and partial enables on a fresh word
        do_write(32'h1004, 32'h1234_5678, 4'b0011);
        look(32'h1004);
        chk(lk_data == 32'h0000_5678, "R8", "partial fresh word", lk_data, 32'h0000_5678);
        do_write(32'h1004, 32'hAABB_CCDD, 4'b1100);
        look(32'h1004);
        chk(lk_hit && lk_data == 32'hAABB_5678, "R3", "merged bytes", lk_data, 32'hAABB_5678);
        chk(!probe_valid && !wb_valid, "R3", "hit causes no traffic", {probe_valid, wb_valid}, 0);
        do_write(32'h1008, 32'hFFFF_FFFF, 4'b0000);
        look(32'h1008);
        chk(!lk_hit, "R8", "empty enables leave word invalid", lk_hit, 0);

        // R4/R5/R7: miss with existing replica in cache
        p_hit_k = 1; p_delay = 2; w_delay = 3;
        do_write(32'h2010, 32'hBEEF_0002, 4'hF);
        #1;
        chk(probe_valid && !wr_ready, "R4", "probe raised, stalled", {probe_valid, wr_ready}, 2'b10);
        wait_idle();
        look(32'h1000);
        chk(!lk_hit, "R7", "old line gone", lk_hit, 0);
        look(32'h2010);
        chk(lk_hit && lk_data == 32'hBEEF_0002, "R7", "new line word", lk_data, 32'hBEEF_0002);
        look(32'h2000);
        chk(!lk_hit, "R7", "other words invalid", lk_hit, 0);

        // R5: miss that needs allocation
        p_hit_k = 0; p_delay = 0; w_delay = 0;
        do_write(32'h3000, 32'h0000_0033, 4'h1);
        wait_idle();

        // R9: flush of a valid buffer
        pulse_flush();
        begin
            bit seen = 0;
            for (int i = 0; i < 20 && !seen; i++) begin @(negedge clk); #1; seen = flush_done; end
            chk(seen, "R9", "flush_done after ack", seen, 1);
        end
        look(32'h3000);
        chk(!lk_hit, "R9", "empty after flush", lk_hit, 0);

        // R10: flush of an empty buffer
        pulse_flush();
        #1;
        chk(flush_done && !probe_valid, "R10", "immediate done", {flush_done, probe_valid}, 2'b10);

        // R12: flush pulse during a write-back
        do_write(32'h4000, 32'h4444_4444, 4'hF);
        p_delay = 1; w_delay = 1;
        do_write(32'h5004, 32'h5555_5555, 4'hF);
        pulse_flush();
        begin
            bit seen = 0;
            for (int i = 0; i < 30 && !seen; i++) begin @(negedge clk); #1; seen = flush_done; end
            chk(seen, "R12", "deferred flush ran", seen, 1);
        end
        look(32'h5004);
        chk(!lk_hit, "R12", "buffer emptied", lk_hit, 0);

        // Randomized stream against the model
        for (int it = 0; it < 400; it++) begin
            int sel = $urandom_range(0, 9);
            p_hit_k = $urandom_range(0, 1);
            p_delay = $urandom_range(0, 3);
            w_delay = $urandom_range(0, 3);
            lk_addr = {19'd0, 3'($urandom_range(1, 3)), 5'd0, 3'($urandom_range(0, 7)), 2'd0};
            if (sel == 0) pulse_flush();
            else if (sel == 1) @(negedge clk);
            else do_write({19'd0, 3'($urandom_range(1, 3)), 5'd0, 3'($urandom_range(0, 7)), 2'd0},
                          $urandom, 4'($urandom_range(0, 15)));
        end
        wait_idle();
        repeat (5) @(negedge clk);
        finish_run();
    end
endmodule